// File: doc/BRIEF.md
# Multi-Select Bus Static RAM

This block is a clocked model of a small static RAM that hangs on an 8-bit processor bus. It holds 128 bytes, picked by a 7-bit address. The bidirectional data pins are split into a write-data input, a read-data output and an output-enable that stands in for the tri-state driver. A read/write line chooses the direction. Six chip-select inputs, four active-low and two active-high, are combined into one enable.

A system clock samples every bus input. The combined select is held in a register. While that registered select is true and read/write is high, the addressed byte appears on the outputs. While it is true and read/write is low, the outputs stay off and the block records the address and data. The byte is committed only once the select pulse ends. In a typical hookup, read/write settles early in the bus cycle, and the selects are driven by a clock phase that is high during the second half of the cycle.

Top module: `sram_bus128`

## Requirements
- R1: The device is selected only when all of `sel_n_i[3:0]` are 0 and both bits of `sel_i[1:0]` are 1. One select at its inactive level blocks both reading and writing.
- R2: `sel_q` is the select state from the previous clock edge. When `sel_q` is true and `rw_i` is 1 (read), `oe_o` is 1 and `rdata_o` equals the byte stored at `addr_i`.
- R3: `oe_o` is 0 in every other case, including a selected cycle with `rw_i` at 0. Whenever `oe_o` is 0, `rdata_o` is all zeros.
- R4: A write is committed at the clock edge on which the select is first seen inactive after being active. No location changes while the select is held active, however many edges pass.
- R5: The address and data that are written are the ones sampled at the last edge on which the select was still active. Values placed on `addr_i` and `wdata_i` after the select drops have no effect.
- R6: Only the `rw_i` value sampled at that last active edge decides whether a write happens. Write means `rw_i` is 0. `oe_o` follows `rw_i` combinationally while `sel_q` is true.
- R7: While `rst_ni` is low, `oe_o` is 0. Memory contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 7 | Byte address |
| wdata_i | input | 8 | Data driven by the bus during a write |
| rw_i | input | 1 | 1 = read, 0 = write |
| sel_n_i | input | 4 | Chip selects, active low |
| sel_i | input | 2 | Chip selects, active high |
| rdata_o | output | 8 | Read data (zero when not driving) |
| oe_o | output | 1 | Output-enable for the bus driver |

## Verification
Every location is loaded with a computed byte pattern and read back. A table of address/data pairs is then written and read, which separates correct address decoding from aliasing. Each of the six selects is dropped in turn during both a read and a write, which shows that every line is part of the combined enable. A select held across several write edges, with the address and data changing each edge, separates commit-at-end from commit-while-active. Changing the address and data as the select falls, and flipping read/write inside the pulse in both directions, confirm which sample is used.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;
  localparam int unsigned ADDR_W   = 7;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned N_SEL_LO = 4;
  localparam int unsigned N_SEL_HI = 2;

  typedef enum logic {
    BUS_WRITE = 1'b0,
    BUS_READ  = 1'b1
  } bus_dir_e;
endpackage

// File: rtl/sram_sel_decode.sv
module sram_sel_decode #(
  parameter int unsigned N_LO = 4,
  parameter int unsigned N_HI = 2
) (
  input  logic [N_LO-1:0] sel_n_i,
  input  logic [N_HI-1:0] sel_i,
  output logic            hit_o
);
  localparam int unsigned N_ALL = N_LO + N_HI;

  logic [N_ALL-1:0] act;

  for (genvar k = 0; k < N_LO; k++) begin : g_lo
    assign act[k] = ~sel_n_i[k];
  end
  for (genvar k = 0; k < N_HI; k++) begin : g_hi
    assign act[N_LO+k] = sel_i[k];
  end

  assign hit_o = &act;
endmodule

// File: rtl/sram_wr_capture.sv
module sram_wr_capture
  import sram_bus_pkg::*;
#(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hit_i,
  input  logic          rw_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          sel_q_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  logic          sel_q;
  bus_dir_e      dir_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      dir_q  <= BUS_READ;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      sel_q <= hit_i;
      // hold the last in-pulse sample for the trailing edge
      if (hit_i) begin
        dir_q  <= bus_dir_e'(rw_i);
        addr_q <= addr_i;
        data_q <= wdata_i;
      end
    end
  end

  assign sel_q_o   = sel_q;
  assign wr_en_o   = sel_q && !hit_i && (dir_q == BUS_WRITE);
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;

  p_commit_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ($past(hit_i) && !hit_i));

  p_commit_dir_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !$past(rw_i));

  p_commit_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_addr_o == $past(addr_i)) && (wr_data_o == $past(wdata_i)));
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/sram_bus128.sv
module sram_bus128
  import sram_bus_pkg::*;
#(
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned N_LO = N_SEL_LO,
  parameter int unsigned N_HI = N_SEL_HI
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            rw_i,
  input  logic [N_LO-1:0] sel_n_i,
  input  logic [N_HI-1:0] sel_i,
  output logic [DW-1:0]   rdata_o,
  output logic            oe_o
);
  logic          hit;
  logic          sel_q;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] arr_rdata;

  sram_sel_decode #(.N_LO(N_LO), .N_HI(N_HI)) u_dec (
    .sel_n_i (sel_n_i),
    .sel_i   (sel_i),
    .hit_o   (hit)
  );

  sram_wr_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit),
    .rw_i      (rw_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .sel_q_o   (sel_q),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  sram_array #(.AW(AW), .DW(DW)) u_arr (
    .clk_i   (clk_i),
    .we_i    (wr_en),
    .waddr_i (wr_addr),
    .wdata_i (wr_data),
    .raddr_i (addr_i),
    .rdata_o (arr_rdata)
  );

  // rw_i is combinational into the enable on purpose
  assign oe_o    = sel_q && (rw_i == BUS_READ);
  assign rdata_o = oe_o ? arr_rdata : '0;

  p_oe_all_sel_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> ($past(sel_n_i) == '0) && ($past(sel_i) == '1));

  p_oe_read_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> rw_i);

  p_quiet_bus_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (rdata_o == '0));

  always_comb begin
    if (!rst_ni) begin
      p_reset_off_r7: assert (!oe_o);
    end
  end
endmodule

// File: tb/sram_bus128_tb_top.sv
`timescale 1ns/1ps
module sram_bus128_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       rw_i = 1'b1;
  logic [3:0] sel_n_i = 4'hF;
  logic [1:0] sel_i = 2'b00;
  logic [7:0] rdata_o;
  logic       oe_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [7:0] model [128];

  localparam logic [14:0] VEC [8] = '{
    {7'h00, 8'hA5}, {7'h7F, 8'h5A}, {7'h01, 8'hFF}, {7'h40, 8'h00},
    {7'h2A, 8'h81}, {7'h55, 8'h7E}, {7'h3F, 8'hC3}, {7'h10, 8'h18}
  };

  always #2 clk_i = ~clk_i;

  sram_bus128 dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .rw_i(rw_i), .sel_n_i(sel_n_i), .sel_i(sel_i),
    .rdata_o(rdata_o), .oe_o(oe_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sel_on();
    sel_n_i = 4'h0; sel_i = 2'b11;
  endtask

  task automatic sel_off();
    sel_n_i = 4'hF; sel_i = 2'b00;
  endtask

  // one-edge write pulse; address and data scrambled as select drops
  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; rw_i = 1'b0; sel_on();
    @(negedge clk_i); addr_i = a ^ 7'h2B; wdata_i = ~d; sel_off();
    @(negedge clk_i); rw_i = 1'b1;
    model[a] = d;
  endtask

  task automatic rd_chk(input logic [6:0] a, input string req);
    @(negedge clk_i); addr_i = a; rw_i = 1'b1; sel_on();
    @(posedge clk_i); #1;
    chk(oe_o === 1'b1, req, oe_o, 1);
    chk(rdata_o === model[a], req, rdata_o, model[a]);
    @(negedge clk_i); sel_off();
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R7: reset state
    repeat (3) @(posedge clk_i);
    #1;
    chk(oe_o === 1'b0, "R7", oe_o, 0);
    chk(rdata_o === 8'h00, "R3", rdata_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R2 fill every location, read all back
    for (int i = 0; i < 128; i++) wr(7'(i), 8'((i * 7 + 1) & 8'hFF));
    for (int i = 0; i < 128; i++) rd_chk(7'(i), "R2");

    // R2 vector table walk
    for (int i = 0; i < 8; i++) wr(VEC[i][14:8], VEC[i][7:0]);
    for (int i = 0; i < 8; i++) rd_chk(VEC[i][14:8], "R2");

    // R1: each single select inactive blocks read and write
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_i); addr_i = 7'h05; wdata_i = 8'hEE; rw_i = 1'b0; sel_on();
      if (k < 4) sel_n_i[k] = 1'b1; else sel_i[k-4] = 1'b0;
      @(negedge clk_i); rw_i = 1'b1;
      @(posedge clk_i); #1;
      chk(oe_o === 1'b0, "R1", oe_o, 0);
      @(negedge clk_i); sel_off();
      rd_chk(7'h05, "R1");
    end

    // R3: selected write cycle leaves outputs off
    @(negedge clk_i); addr_i = 7'h06; wdata_i = 8'h66; rw_i = 1'b0; sel_on();
    @(posedge clk_i); #1;
    chk(oe_o === 1'b0, "R3", oe_o, 0);
    chk(rdata_o === 8'h00, "R3", rdata_o, 0);
    @(negedge clk_i); sel_off();
    @(negedge clk_i); rw_i = 1'b1;
    model[7'h06] = 8'h66;
    rd_chk(7'h06, "R3");

    // R4: held select, only the final sample commits
    @(negedge clk_i); addr_i = 7'h0A; wdata_i = 8'h11; rw_i = 1'b0; sel_on();
    @(negedge clk_i); addr_i = 7'h14; wdata_i = 8'h22;
    @(negedge clk_i); addr_i = 7'h1E; wdata_i = 8'h33;
    @(negedge clk_i); sel_off();
    @(negedge clk_i); rw_i = 1'b1;
    model[7'h1E] = 8'h33;
    rd_chk(7'h0A, "R4");
    rd_chk(7'h14, "R4");
    rd_chk(7'h1E, "R4");

    // R5: wr() scrambles addr/data at the drop
    wr(7'h20, 8'h9C);
    rd_chk(7'h20, "R5");
    rd_chk(7'h20 ^ 7'h2B, "R5");

    // R6: write turned into read inside the pulse
    @(negedge clk_i); addr_i = 7'h30; wdata_i = 8'hAB; rw_i = 1'b0; sel_on();
    @(negedge clk_i); rw_i = 1'b1; #0.5;
    chk(oe_o === 1'b1, "R6", oe_o, 1);
    @(negedge clk_i); sel_off();
    rd_chk(7'h30, "R6");

    // R6: read turned into write inside the pulse
    @(negedge clk_i); addr_i = 7'h31; wdata_i = 8'h4D; rw_i = 1'b1; sel_on();
    @(negedge clk_i); rw_i = 1'b0; #0.5;
    chk(oe_o === 1'b0, "R6", oe_o, 0);
    @(negedge clk_i); sel_off();
    @(negedge clk_i); rw_i = 1'b1;
    model[7'h31] = 8'h4D;
    rd_chk(7'h31, "R6");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule